// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory. It samples the SCL and SDA lines on a fast system clock and detects START and STOP conditions. It shifts in a control byte, a word address and data bytes. It acknowledges by asserting an open-drain pull-down enable on SDA, and it uses the same enable to send read data. One internal address pointer serves both reads and writes. The block-select field of the control byte supplies the pointer's upper bits, and the word-address byte supplies its low eight bits.

Reads come from a synchronous memory read port. The engine fetches the next byte while the acknowledge clock is low, so the byte is ready before its first bit is driven. Write data does not go to the array. Each accepted data byte is handed to a separate page buffer as an address and data pair. At STOP the engine signals the buffer to commit its contents. If a START arrives instead, it signals the buffer to discard them. While the external write cycle is in progress (`busy_i` high), the engine acknowledges nothing. A master can use that to poll for completion.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A START, including a repeated START, begins a new control byte from any state. A STOP returns the engine to idle with SDA released, and it gives no commit when no data byte was accepted.
- R2: A control byte whose upper nibble is 1010 is acknowledged. Any other value is not acknowledged, and the bytes that follow are ignored until the next START.
- R3: For every accepted control, address and write-data byte, `sda_oe_o` is 1 through the whole ninth clock.
- R4: While `busy_i` is high, no byte is acknowledged, the control byte included. Acknowledges resume once `busy_i` is low.
- R5: Bits [BLOCK_BITS:1] of the control byte (bits 2:1 by default) are loaded into the pointer's upper bits on every accepted control byte. Bit 3 has no effect. Bit 0 selects the operation: 1 is read, 0 is write.
- R6: In a write, the byte after the control byte loads the pointer's low 8 bits. Each following data byte gives one `pbuf_we_o` pulse carrying the pointer and the byte. A STOP after at least one data byte gives exactly one `commit_o` pulse.
- R7: Each data byte increments only the low PAGE_BITS (4) pointer bits, wrapping within the page. The upper bits stay fixed, so more than 16 bytes overwrite earlier ones in arrival order.
- R8: Random read: a write control byte and an address byte, then a repeated START and a read control byte, return first the byte at the loaded address.
- R9: Current-address read: a read returns the byte at the pointer. The pointer is the last read address plus one, or the last written location advanced as in R7.
- R10: In a read, each master ACK makes the engine send the next byte. The pointer increments by one per byte and wraps from the last array location to 0.
- R11: After a master NACK, SDA stays released until the next START.
- R12: Read bytes are sent MSB first. `sda_oe_o` changes only while SCL is low.
- R13: A START that arrives while write data is pending gives one `abort_o` pulse and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy_i | input | 1 | Internal write cycle in progress |
| mem_raddr_o | output | 8+BLOCK_BITS | Synchronous array read address (the pointer) |
| mem_rdata_i | input | 8 | Array read data, one cycle after the address |
| pbuf_we_o | output | 1 | One-cycle strobe for a write-data byte |
| pbuf_addr_o | output | 8+BLOCK_BITS | Target address of the strobed byte |
| pbuf_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | Pulse: STOP ended a write with pending data |
| abort_o | output | 1 | Pulse: START discarded pending write data |

## Verification
Some properties are checked on every cycle: the SDA drive changes only while the synchronized SCL is low, no acknowledge starts while busy is high, the engine is quiet when idle, buffer strobes occur only during an acknowledge, a commit is preceded by STOP, and commit and abort never occur together. Other behaviour can only be shown by the bench's bus transactions. That covers the data values returned by current-address, random and sequential reads, page roll-over and wrap-around addressing, the ignored block-select bit, busy polling, and a discarded write. The bench checks these against its own reference memory.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
`timescale 1ns/1ps
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // {scl, sda}; idle bus is high
  logic [1:0] pipe_q [STAGES];
  logic [1:0] prev_q;
  logic [1:0] cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      pipe_q[0] <= {scl_i, sda_i};
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign cur        = pipe_q[STAGES-1];
  assign scl_o      = cur[1];
  assign sda_o      = cur[0];
  assign scl_rise_o = cur[1] & ~prev_q[1];
  assign scl_fall_o = ~cur[1] & prev_q[1];
  assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
  assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/eep_addr_ptr.sv
`timescale 1ns/1ps
module eep_addr_ptr #(
  parameter  int BLOCK_BITS = 2,
  parameter  int PAGE_BITS  = 4,
  localparam int AW         = 8 + BLOCK_BITS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  blk_we_i,
  input  logic [BLOCK_BITS-1:0] blk_i,
  input  logic                  word_we_i,
  input  logic [7:0]            word_i,
  input  logic                  page_inc_i,
  input  logic                  lin_inc_i,
  output logic [AW-1:0]         ptr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (blk_we_i) begin
      ptr_q[AW-1:8] <= blk_i;
    end else if (word_we_i) begin
      ptr_q[7:0] <= word_i;
    end else if (page_inc_i) begin
      ptr_q[PAGE_BITS-1:0] <= ptr_q[PAGE_BITS-1:0] + PAGE_BITS'(1);
    end else if (lin_inc_i) begin
      ptr_q <= ptr_q + AW'(1);  // wraps at end of array
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter  int BLOCK_BITS = 2,
  parameter  int PAGE_BITS  = 4,
  localparam int AW         = 8 + BLOCK_BITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          busy_i,
  output logic [AW-1:0] mem_raddr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          pbuf_we_o,
  output logic [AW-1:0] pbuf_addr_o,
  output logic [7:0]    pbuf_data_o,
  output logic          commit_o,
  output logic          abort_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_bus_sync #(.STAGES(2)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  eep_state_e    state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    rx_q;
  logic [6:0]    tx_q;
  logic          oe_q, wr_pend_q;
  logic          pbuf_we_q, commit_q, abort_q;
  logic [AW-1:0] pbuf_addr_q;
  logic [7:0]    pbuf_data_q;
  logic [AW-1:0] ptr;

  logic byte_done, ack_end, rx_state, accept;
  logic blk_we, word_we, page_inc, lin_inc;

  always_comb begin
    byte_done = scl_fall && (bit_cnt_q == 4'd8);
    ack_end   = scl_fall && (bit_cnt_q == 4'd9);
    rx_state  = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDATA);
    accept    = byte_done && rx_state && !busy_i && !start_ev && !stop_ev &&
                ((state_q != ST_CTRL) || (rx_q[7:4] == DEV_CODE));
    blk_we    = accept && (state_q == ST_CTRL);
    word_we   = accept && (state_q == ST_ADDR);
    page_inc  = accept && (state_q == ST_WDATA);
    lin_inc   = ack_end && (state_q == ST_RDATA) && !start_ev && !stop_ev;
  end

  eep_addr_ptr #(.BLOCK_BITS(BLOCK_BITS), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_we_i   (blk_we),
    .blk_i      (rx_q[BLOCK_BITS:1]),
    .word_we_i  (word_we),
    .word_i     (rx_q),
    .page_inc_i (page_inc),
    .lin_inc_i  (lin_inc),
    .ptr_o      (ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      oe_q        <= 1'b0;
      wr_pend_q   <= 1'b0;
      pbuf_we_q   <= 1'b0;
      pbuf_addr_q <= '0;
      pbuf_data_q <= '0;
      commit_q    <= 1'b0;
      abort_q     <= 1'b0;
    end else begin
      pbuf_we_q <= 1'b0;
      commit_q  <= 1'b0;
      abort_q   <= 1'b0;
      if (start_ev) begin
        state_q   <= ST_CTRL;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        abort_q   <= wr_pend_q;
        wr_pend_q <= 1'b0;
      end else if (stop_ev) begin
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        commit_q  <= wr_pend_q;
        wr_pend_q <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt_q < 4'd8) begin
            rx_q      <= {rx_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (bit_cnt_q == 4'd8) begin
            bit_cnt_q <= 4'd9;
            // master NACK ends the read
            if (state_q == ST_RDATA && sda_s) state_q <= ST_IDLE;
          end
        end else if (scl_fall) begin
          if (bit_cnt_q == 4'd8) begin
            if (state_q == ST_RDATA) begin
              oe_q <= 1'b0;  // master's acknowledge slot
            end else if (accept) begin
              oe_q <= 1'b1;
              unique case (state_q)
                ST_CTRL:  state_q <= rx_q[0] ? ST_RDATA : ST_ADDR;
                ST_ADDR:  state_q <= ST_WDATA;
                default: begin
                  pbuf_we_q   <= 1'b1;
                  pbuf_addr_q <= ptr;
                  pbuf_data_q <= rx_q;
                  wr_pend_q   <= 1'b1;
                end
              endcase
            end else begin
              state_q <= ST_IDLE;
              oe_q    <= 1'b0;
            end
          end else if (bit_cnt_q == 4'd9) begin
            bit_cnt_q <= '0;
            if (state_q == ST_RDATA) begin
              tx_q <= mem_rdata_i[6:0];
              oe_q <= ~mem_rdata_i[7];
            end else begin
              oe_q <= 1'b0;
            end
          end else if (state_q == ST_RDATA && bit_cnt_q != 4'd0) begin
            tx_q <= {tx_q[5:0], 1'b0};
            oe_q <= ~tx_q[6];
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_raddr_o = ptr;
  assign pbuf_we_o   = pbuf_we_q;
  assign pbuf_addr_o = pbuf_addr_q;
  assign pbuf_data_o = pbuf_data_q;
  assign commit_o    = commit_q;
  assign abort_o     = abort_q;
endmodule

// File: rtl/eep_slave_chk.sv
`timescale 1ns/1ps
module eep_slave_chk
  import eep_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s_i,
  input logic       stop_i,
  input logic       busy_i,
  input logic       sda_oe_i,
  input logic       pbuf_we_i,
  input logic       commit_i,
  input logic       abort_i,
  input eep_state_e state_i
);
  assert_drive_scl_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_s_i);

  assert_no_ack_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> !$past(busy_i));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_i);

  assert_wr_in_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbuf_we_i |-> sda_oe_i);

  assert_commit_on_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> $past(stop_i));

  assert_commit_abort_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_i && abort_i));
endmodule

bind i2c_eeprom_slave eep_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_s_i   (scl_s),
  .stop_i    (stop_ev),
  .busy_i    (busy_i),
  .sda_oe_i  (sda_oe_o),
  .pbuf_we_i (pbuf_we_o),
  .commit_i  (commit_o),
  .abort_i   (abort_o),
  .state_i   (state_q)
);

// File: tb/sim_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module sim_i2c_eeprom_slave;
  localparam int BLOCK_BITS = 2;
  localparam int AW         = 8 + BLOCK_BITS;
  localparam int DEPTH      = 1 << AW;
  localparam int Q          = 10;
  localparam int BUSY_CYC   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, pbuf_we, commit, abort_p, busy;
  logic [AW-1:0] raddr, pbuf_addr;
  logic [7:0] rdata, pbuf_data;
  wire sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.BLOCK_BITS(BLOCK_BITS), .PAGE_BITS(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .busy_i(busy), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .pbuf_we_o(pbuf_we), .pbuf_addr_o(pbuf_addr), .pbuf_data_o(pbuf_data),
    .commit_o(commit), .abort_o(abort_p)
  );

  int n_chk = 0, n_fail = 0, n_commit = 0, n_abort = 0, n_bad_edge = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_init(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  // array and page buffer model driven by the DUT's outputs
  logic [7:0] dmem [DEPTH];
  logic [7:0] ref_mem [DEPTH];
  logic [AW+7:0] stage_q [$];
  int busy_cnt = 0;
  assign busy = (busy_cnt != 0);

  always @(posedge clk) begin
    rdata <= dmem[raddr];
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (pbuf_we) stage_q.push_back({pbuf_addr, pbuf_data});
    if (abort_p) stage_q.delete();
    if (commit) begin
      foreach (stage_q[i]) dmem[stage_q[i][AW+7:8]] <= stage_q[i][7:0];
      stage_q.delete();
      busy_cnt <= BUSY_CYC;
    end
  end

  // scoreboard
  typedef struct {int val; string tag;} exp_t;
  exp_t exp_q [$];
  int obs_q [$];
  logic [AW+7:0] exp_wr [$];
  logic prev_oe = 1'b0;

  always @(negedge clk) begin
    exp_t e;
    int o;
    logic [AW+7:0] w;
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      chk(o == e.val, e.tag, o, e.val);
    end
    if (pbuf_we) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R6 unexpected buffer write", int'({pbuf_addr, pbuf_data}), 0);
      end else begin
        w = exp_wr.pop_front();
        chk({pbuf_addr, pbuf_data} == w, "R6/R7 buffer write", int'({pbuf_addr, pbuf_data}), int'(w));
      end
    end
    if (commit) n_commit++;
    if (abort_p) n_abort++;
    if (rst_n && sda_oe !== prev_oe && scl_m) n_bad_edge++;
    prev_oe = sda_oe;
  end

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2 * Q);
  endtask

  task automatic bit_out(logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bit_in(output logic s);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    s = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, string tag);
    logic s;
    exp_q.push_back('{int'(exp_ack), tag});
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(s);
    obs_q.push_back(int'(!s));
  endtask

  task automatic recv_byte(logic [7:0] exp_v, bit mack, string tag);
    logic s;
    logic [7:0] v;
    exp_q.push_back('{int'(exp_v), tag});
    for (int i = 7; i >= 0; i--) begin
      bit_in(s);
      v[i] = s;
    end
    bit_out(!mack);
    obs_q.push_back(int'(v));
  endtask

  task automatic wait_idle();
    while (busy) wq(1);
    wq(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (R1..R13 run incomplete)");
    summary();
    $finish;
  end

  initial begin
    logic s;
    logic [AW-1:0] a;
    for (int i = 0; i < DEPTH; i++) begin
      dmem[i] = f_init(i);
      ref_mem[i] = f_init(i);
    end
    wq(5);
    chk(sda_oe == 1'b0, "R1 reset SDA released", int'(sda_oe), 0);
    chk(pbuf_we == 1'b0 && commit == 1'b0 && abort_p == 1'b0, "R1 reset strobes low",
        int'({pbuf_we, commit, abort_p}), 0);
    rst_n = 1'b1;
    wq(5);

    // bad code ignored, repeated START recovers, STOP without data gives no commit
    bus_start();
    send_byte(8'hB0, 1'b0, "R2 wrong device code");
    send_byte(8'hA0, 1'b0, "R2 byte ignored after wrong code");
    bus_start();
    send_byte(8'hA2, 1'b1, "R1 repeated START restarts control byte");
    bus_stop();
    wq(4);
    chk(n_commit == 0, "R1 STOP without data", n_commit, 0);

    // byte write to block 1 with bit 3 set
    bus_start();
    send_byte(8'hAA, 1'b1, "R5 control with ignored bit 3");
    send_byte(8'h10, 1'b1, "R3 address ack");
    exp_wr.push_back({10'h110, 8'h5C});
    send_byte(8'h5C, 1'b1, "R6 data ack");
    bus_stop();
    ref_mem[10'h110] = 8'h5C;
    wq(4);
    chk(n_commit == 1, "R6 commit after byte write", n_commit, 1);

    // polling during busy
    bus_start();
    send_byte(8'hA2, 1'b0, "R4 no ack while busy");
    bus_stop();
    wait_idle();
    bus_start();
    send_byte(8'hA2, 1'b1, "R4 ack after write cycle");
    bus_stop();

    // current-address read
    bus_start();
    send_byte(8'hA3, 1'b1, "R9 read control");
    recv_byte(ref_mem[10'h111], 1'b0, "R9/R12 current address read");
    bus_stop();

    // random read then sequential, then NACK release
    bus_start();
    send_byte(8'hA2, 1'b1, "R8 write control");
    send_byte(8'h10, 1'b1, "R8 address");
    bus_start();
    send_byte(8'hA3, 1'b1, "R8 read control");
    recv_byte(8'h5C, 1'b1, "R8 random read of written byte");
    recv_byte(ref_mem[10'h111], 1'b1, "R10 sequential next");
    recv_byte(ref_mem[10'h112], 1'b0, "R10 sequential third");
    bit_in(s);
    chk(s == 1'b1, "R11 SDA released after NACK", int'(s), 1);
    bus_stop();

    // page write with roll-over in block 2
    bus_start();
    send_byte(8'hA4, 1'b1, "R7 control");
    send_byte(8'h2E, 1'b1, "R7 address");
    for (int k = 0; k < 18; k++) begin
      a = {2'b10, 4'h2, 4'((14 + k) % 16)};
      exp_wr.push_back({a, 8'(8'h80 + k)});
      send_byte(8'(8'h80 + k), 1'b1, "R3/R7 page data ack");
      ref_mem[a] = 8'(8'h80 + k);
    end
    bus_stop();
    wq(4);
    chk(n_commit == 2, "R7 single commit for page", n_commit, 2);
    bus_start();
    send_byte(8'hA4, 1'b0, "R4 no ack while page busy");
    bus_stop();
    wait_idle();
    bus_start();
    send_byte(8'hA5, 1'b1, "R9 read after page write");
    for (int o = 0; o < 16; o++)
      recv_byte(ref_mem[10'h220 + o], o < 15, "R7/R9 page contents");
    bus_stop();

    // sequential wrap at end of array
    bus_start();
    send_byte(8'hA6, 1'b1, "R10 control block 3");
    send_byte(8'hFE, 1'b1, "R10 address");
    bus_start();
    send_byte(8'hA7, 1'b1, "R10 read control");
    recv_byte(ref_mem[10'h3FE], 1'b1, "R10 byte 3FE");
    recv_byte(ref_mem[10'h3FF], 1'b1, "R10 byte 3FF");
    recv_byte(ref_mem[10'h000], 1'b0, "R10 wrap to zero");
    bus_stop();

    // write discarded by repeated START
    bus_start();
    send_byte(8'hA0, 1'b1, "R13 control");
    send_byte(8'h05, 1'b1, "R13 address");
    exp_wr.push_back({10'h005, 8'h11});
    send_byte(8'h11, 1'b1, "R13 data");
    bus_start();
    send_byte(8'hA0, 1'b1, "R13 control again");
    send_byte(8'h05, 1'b1, "R13 address again");
    bus_start();
    send_byte(8'hA1, 1'b1, "R13 read control");
    recv_byte(ref_mem[10'h005], 1'b0, "R13 location unchanged");
    bus_stop();
    wq(4);
    chk(n_abort == 1, "R13 abort pulse count", n_abort, 1);
    chk(n_commit == 2, "R13 no commit", n_commit, 2);
    chk(busy == 1'b0, "R13 no write cycle started", int'(busy), 0);

    wq(20);
    chk(n_bad_edge == 0, "R12 SDA drive changed while SCL high", n_bad_edge, 0);
    chk(exp_q.size() == 0 && obs_q.size() == 0, "R3 scoreboard drained",
        exp_q.size() + obs_q.size(), 0);
    chk(exp_wr.size() == 0, "R6 all expected writes seen", exp_wr.size(), 0);
    summary();
    $finish;
  end
endmodule